// File: doc/BRIEF.md
# SGRAM Command and Initialization Controller

This block turns a one-word request interface into command cycles on a single-data-rate SGRAM/SDRAM bus. After synchronous reset is released it closes every bank, then programs the device mode word with a burst length of one and the chosen CAS latency. It then serves one access at a time. Each access opens a row, issues one column read or write and closes that bank with a single-bank precharge. Parameters set the spacing between commands, and NOP cycles fill the gaps.

All command, address, mask and write-data pins come from registers. Read data is taken straight from the device data inputs in the cycle it is valid, and a one-cycle strobe marks that cycle. The data bus is split into an output word, an input word and an output enable.

Top module: `sgram_cmd_ctrl`

## Requirements
- R1: While `rst` is high, chip select is high, the output enable is low, `dqm` is all ones and both `ready` and `rd_valid` are low.
- R2: Commands use the active-low pin tuple {cs_n,ras_n,cas_n,we_n}: NOP 0111, row open 0011, read 0101, write 0100, precharge 0010, mode load 0000.
- R3: The first clock edge after reset release puts a precharge with address bit 9 high on the bus, which closes all banks. Exactly RP_GAP cycles later the mode load follows. Its address has CAS_LAT in bits 6:4 and zero in every other bit.
- R4: `ready` first rises MRD_GAP-1 cycles after the mode load. It is high only while no access is in flight. A request presented while `ready` is low is ignored.
- R5: A request sampled with `ready` high yields a row open in the next cycle, with the bank on address bit 10 and the row on bits 9:0.
- R6: The column command comes exactly RCD_GAP cycles after the row open. It is a write when `req_write` is 1 and a read otherwise. Its address has the bank on bit 10, bits 9:8 at zero and the column on bits 7:0.
- R7: A precharge with bit 9 low and the bank on bit 10 comes exactly CPRE_GAP cycles after the column command. `ready` rises again RP_GAP-1 cycles after that precharge.
- R8: The output enable is high only in the write command cycle. In that cycle `sd_dq_out` carries the request word and `sd_dqm` carries the request byte mask (1 = byte masked).
- R9: A read drives `sd_dqm` to all zeros in the single cycle CAS_LAT-2 after the read command. Outside write cycles and that cycle, `sd_dqm` is all ones.
- R10: `rd_valid` is high exactly CAS_LAT cycles after a read command, and in that cycle `rd_data` equals `sd_dq_in`. At all other times `rd_data` is zero.
- R11: Clock enable is always high and the special-function pin is always low.
- R12: In every cycle after reset in which R3, R5, R6 and R7 place no command, the bus carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Bank number |
| req_row | input | 10 | Row address |
| req_col | input | 8 | Column address |
| req_wdata | input | 128 | Write word |
| req_wmask | input | 16 | Byte mask for the write, 1 = masked |
| ready | output | 1 | Request can be taken this cycle |
| rd_data | output | 128 | Returned read word |
| rd_valid | output | 1 | Read word valid |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 11 | Shared address bus |
| sd_dqm | output | 16 | Byte masks |
| sd_cke | output | 1 | Clock enable |
| sd_dsf | output | 1 | Special-function select |
| sd_dq_out | output | 128 | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 128 | Data from the device |

## Verification
With a CAS latency of three, read data comes back in the same cycle that `ready` reasserts after the closing precharge. A new request accepted then produces a row open in the cycle right after the read strobe. The bench keeps the next request valid the whole time and issues reads back to back to force this overlap. A cycle-by-cycle model then checks the read strobe, the returned word, the mask pins and the next command all in that one cycle.

// File: rtl/sgram_pkg.sv
package sgram_pkg;

    localparam int SD_ADDR_W = 11;
    localparam int ROW_W     = 10;
    localparam int COL_W     = 8;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_INIT_PRE,
        ST_INIT_LMR,
        ST_IDLE,
        ST_COL,
        ST_CLOSE,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        sd_cmd_e                cmd;
        logic [SD_ADDR_W-1:0]   addr;
        logic                   wr_en;
    } sd_issue_t;

    function automatic logic [SD_ADDR_W-1:0] addr_open(input logic bank,
                                                       input logic [ROW_W-1:0] row);
        return {bank, row};
    endfunction

    function automatic logic [SD_ADDR_W-1:0] addr_column(input logic bank,
                                                         input logic [COL_W-1:0] col);
        return {bank, 2'b00, col};
    endfunction

    function automatic logic [SD_ADDR_W-1:0] addr_close(input logic all_banks,
                                                        input logic bank);
        return {(all_banks ? 1'b0 : bank), all_banks, 9'b0};
    endfunction

    function automatic logic [SD_ADDR_W-1:0] addr_mode(input logic [2:0] lat);
        return {4'b0000, lat, 4'b0000};
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sgram_seq.sv
module sgram_seq
    import sgram_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int CAS_LAT  = 2,
    parameter int RCD_GAP  = 2,
    parameter int RP_GAP   = 2,
    parameter int MRD_GAP  = 2,
    parameter int CPRE_GAP = 2,
    localparam int MASK_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_wmask,
    output logic              ready,
    output sd_issue_t         issue,
    output logic [DATA_W-1:0] wdata,
    output logic [MASK_W-1:0] wmask
);

    localparam int MAX_GAP = max_of(max_of(RCD_GAP, RP_GAP), max_of(MRD_GAP, CPRE_GAP));
    localparam int CNT_W   = $clog2(MAX_GAP + 1) + 1;

    seq_state_e         st, st_n, tgt, tgt_n, tgt_sel;
    logic [CNT_W-1:0]   cnt, cnt_n, gap_sel;
    logic               launch, take;
    logic               q_write, q_bank;
    logic [COL_W-1:0]   q_col;

    always_comb begin
        issue   = '{cmd: CMD_NOP, addr: '0, wr_en: 1'b0};
        launch  = 1'b0;
        take    = 1'b0;
        gap_sel = '0;
        tgt_sel = ST_IDLE;
        case (st)
            ST_INIT_PRE: begin
                issue.cmd  = CMD_PRE;
                issue.addr = addr_close(1'b1, 1'b0);
                launch     = 1'b1;
                gap_sel    = CNT_W'(RP_GAP);
                tgt_sel    = ST_INIT_LMR;
            end
            ST_INIT_LMR: begin
                issue.cmd  = CMD_LMR;
                issue.addr = addr_mode(3'(CAS_LAT));
                launch     = 1'b1;
                gap_sel    = CNT_W'(MRD_GAP);
                tgt_sel    = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    issue.cmd  = CMD_ACT;
                    issue.addr = addr_open(req_bank, req_row);
                    take       = 1'b1;
                    launch     = 1'b1;
                    gap_sel    = CNT_W'(RCD_GAP);
                    tgt_sel    = ST_COL;
                end
            end
            ST_COL: begin
                issue.cmd   = q_write ? CMD_WR : CMD_RD;
                issue.addr  = addr_column(q_bank, q_col);
                issue.wr_en = q_write;
                launch      = 1'b1;
                gap_sel     = CNT_W'(CPRE_GAP);
                tgt_sel     = ST_CLOSE;
            end
            ST_CLOSE: begin
                issue.cmd  = CMD_PRE;
                issue.addr = addr_close(1'b0, q_bank);
                launch     = 1'b1;
                gap_sel    = CNT_W'(RP_GAP);
                tgt_sel    = ST_IDLE;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_n  = st;
        tgt_n = tgt;
        cnt_n = cnt;
        if (launch) begin
            if (gap_sel <= CNT_W'(1)) begin
                st_n = tgt_sel;
            end else begin
                st_n  = ST_WAIT;
                tgt_n = tgt_sel;
                cnt_n = gap_sel - CNT_W'(2);
            end
        end else if (st == ST_WAIT) begin
            if (cnt == '0) st_n  = tgt;
            else           cnt_n = cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_INIT_PRE;
            tgt <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            tgt <= tgt_n;
            cnt <= cnt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_write <= 1'b0;
            q_bank  <= 1'b0;
            q_col   <= '0;
            wdata   <= '0;
            wmask   <= '0;
        end else if (take) begin
            q_write <= req_write;
            q_bank  <= req_bank;
            q_col   <= req_col;
            wdata   <= req_wdata;
            wmask   <= req_wmask;
        end
    end

    assign ready = (st == ST_IDLE);

endmodule

// File: rtl/sgram_pin_reg.sv
module sgram_pin_reg
    import sgram_pkg::*;
#(
    parameter int DATA_W  = 128,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sd_issue_t            issue,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [MASK_W-1:0]    wmask,
    output logic [3:0]           cmd_pins,
    output logic [SD_ADDR_W-1:0] addr,
    output logic                 dq_oe,
    output logic [DATA_W-1:0]    dq_out,
    output logic [MASK_W-1:0]    wr_dqm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_pins <= CMD_INH;
            addr     <= '0;
            dq_oe    <= 1'b0;
            dq_out   <= '0;
            wr_dqm   <= '1;
        end else begin
            cmd_pins <= issue.cmd;
            addr     <= issue.addr;
            dq_oe    <= issue.wr_en;
            dq_out   <= issue.wr_en ? wdata : '0;
            wr_dqm   <= issue.wr_en ? wmask : '1;
        end
    end

endmodule

// File: rtl/sgram_rd_track.sv
module sgram_rd_track #(
    parameter int DATA_W  = 128,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_dqm_low,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    generate
        if (CAS_LAT < 2 || CAS_LAT > 3) begin : g_bad_lat
            $error("CAS_LAT must be 2 or 3");
        end
    endgenerate

    // bit k is high k cycles after a read command was on the bus
    logic [CAS_LAT:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else     age <= {age[CAS_LAT-1:0], rd_issue};
    end

    assign rd_dqm_low = age[CAS_LAT-2];
    assign rd_valid   = age[CAS_LAT];
    assign rd_data    = rd_valid ? dq_in : '0;

endmodule

// File: rtl/sgram_cmd_ctrl.sv
module sgram_cmd_ctrl
    import sgram_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int CAS_LAT  = 2,
    parameter int RCD_GAP  = 2,
    parameter int RP_GAP   = 2,
    parameter int MRD_GAP  = 2,
    parameter int CPRE_GAP = 2,
    localparam int MASK_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_bank,
    input  logic [9:0]        req_row,
    input  logic [7:0]        req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_wmask,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [10:0]       sd_addr,
    output logic [MASK_W-1:0] sd_dqm,
    output logic              sd_cke,
    output logic              sd_dsf,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);

    sd_issue_t         issue;
    logic [DATA_W-1:0] q_wdata;
    logic [MASK_W-1:0] q_wmask;
    logic [3:0]        cmd_pins;
    logic [MASK_W-1:0] wr_dqm;
    logic              rd_dqm_low;

    sgram_seq #(
        .DATA_W(DATA_W), .CAS_LAT(CAS_LAT), .RCD_GAP(RCD_GAP),
        .RP_GAP(RP_GAP), .MRD_GAP(MRD_GAP), .CPRE_GAP(CPRE_GAP)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_wmask(req_wmask),
        .ready(ready), .issue(issue), .wdata(q_wdata), .wmask(q_wmask)
    );

    sgram_pin_reg #(.DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst(rst), .issue(issue),
        .wdata(q_wdata), .wmask(q_wmask),
        .cmd_pins(cmd_pins), .addr(sd_addr),
        .dq_oe(sd_dq_oe), .dq_out(sd_dq_out), .wr_dqm(wr_dqm)
    );

    sgram_rd_track #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_rd (
        .clk(clk), .rst(rst),
        .rd_issue(issue.cmd == CMD_RD),
        .dq_in(sd_dq_in),
        .rd_dqm_low(rd_dqm_low), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins;
    assign sd_dqm = wr_dqm & ~{MASK_W{rd_dqm_low}};
    assign sd_cke = 1'b1;
    assign sd_dsf = 1'b0;

endmodule

// File: rtl/sgram_cmd_ctrl_chk.sv
module sgram_cmd_ctrl_chk #(
    parameter int CAS_LAT = 2,
    parameter int MASK_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_bank,
    input logic [9:0]        req_row,
    input logic              ready,
    input logic              rd_valid,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [10:0]       sd_addr,
    input logic [MASK_W-1:0] sd_dqm,
    input logic              sd_cke,
    input logic              sd_dsf,
    input logic              sd_dq_oe
);

    logic [3:0] pins;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    p_reset_inhibit_r1: assert property (@(posedge clk)
        rst |=> (sd_cs_n && !sd_dq_oe && !ready && !rd_valid));

    p_first_close_all_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (pins == 4'b0010 && sd_addr[9]));

    p_accept_open_r5: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> (pins == 4'b0011
                                  && sd_addr[10] == $past(req_bank)
                                  && sd_addr[9:0] == $past(req_row)));

    p_col_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0101 || pins == 4'b0100) |-> (sd_addr[9:8] == 2'b00));

    p_oe_only_write_r8: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (pins == 4'b0100));

    p_read_mask_lead_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(sd_dqm == '0, 2));

    p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(pins == 4'b0101, CAS_LAT));

    p_pins_static_r11: assert property (@(posedge clk) disable iff (rst)
        (sd_cke && !sd_dsf));

endmodule

bind sgram_cmd_ctrl sgram_cmd_ctrl_chk #(.CAS_LAT(CAS_LAT), .MASK_W(MASK_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .ready(ready), .rd_valid(rd_valid),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_cke(sd_cke), .sd_dsf(sd_dsf),
    .sd_dq_oe(sd_dq_oe)
);

// File: tb/sgram_cmd_ctrl_test.sv
module sgram_cmd_ctrl_test;

    localparam int CL   = 3;
    localparam int RCD  = 2;
    localparam int RP   = 2;
    localparam int MRD  = 2;
    localparam int CPRE = 2;
    localparam int NREQ = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
    logic [9:0]   req_row = '0;
    logic [7:0]   req_col = '0;
    logic [127:0] req_wdata = '0;
    logic [15:0]  req_wmask = '0;
    logic         ready, rd_valid;
    logic [127:0] rd_data, sd_dq_out;
    logic [127:0] sd_dq_in = '0;
    logic         sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dsf, sd_dq_oe;
    logic [10:0]  sd_addr;
    logic [15:0]  sd_dqm;

    sgram_cmd_ctrl #(.CAS_LAT(CL), .RCD_GAP(RCD), .RP_GAP(RP),
                     .MRD_GAP(MRD), .CPRE_GAP(CPRE)) uut (.*);

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model: expected events keyed by bus cycle
    logic [3:0]  e_cmd  [int];
    logic [10:0] e_addr [int];
    string       e_tag  [int];
    int          e_wr   [int];
    bit          e_dqm0 [int];
    bit          e_rdv  [int];
    int          ready_from;
    int          last_cmd;

    // request table
    bit          t_wr   [NREQ] = '{1, 0, 0, 1, 0, 1, 0, 0};
    bit          t_bank [NREQ] = '{0, 1, 0, 1, 1, 0, 0, 1};
    logic [9:0]  t_row  [NREQ] = '{10'h005, 10'h3FF, 10'h200, 10'h001,
                                   10'h155, 10'h2AA, 10'h000, 10'h0F0};
    logic [7:0]  t_col  [NREQ] = '{8'h03, 8'hFF, 8'h80, 8'h00,
                                   8'h55, 8'hAA, 8'h01, 8'h7E};
    logic [15:0] t_mask [NREQ] = '{16'h00F0, 16'h0, 16'h0, 16'h0000,
                                   16'h0, 16'hFFFF, 16'h0, 16'h0};

    function automatic logic [127:0] wword(input int i);
        return {4{32'hA5000000 + 32'(i) * 32'h01010101}};
    endfunction

    function automatic logic [127:0] inword(input int t);
        return {4{(32'(t) * 32'h9E3779B9) ^ 32'h13579BDF}};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int t, input logic [3:0] c, input logic [10:0] a, input string tag);
        e_cmd[t]  = c;
        e_addr[t] = a;
        e_tag[t]  = tag;
    endtask

    task automatic schedule(input int r, input int i);
        int a, c, p;
        a = r + 1;
        put(a, 4'b0011, {t_bank[i], t_row[i]}, "R5 open");
        c = a + RCD;
        if (t_wr[i]) begin
            put(c, 4'b0100, {t_bank[i], 2'b00, t_col[i]}, "R6 write");
            e_wr[c] = i;
        end else begin
            put(c, 4'b0101, {t_bank[i], 2'b00, t_col[i]}, "R6 read");
            e_dqm0[c + CL - 2] = 1'b1;
            e_rdv[c + CL]      = 1'b1;
        end
        p = c + CPRE;
        put(p, 4'b0010, {t_bank[i], 1'b0, 9'b0}, "R7 close");
        ready_from = p + RP - 1;
        last_cmd   = p;
    endtask

    task automatic compare_cycle(input int t);
        logic [3:0]   xc;
        logic [15:0]  xm;
        bit           xrdy;
        string        tg;
        xc = e_cmd.exists(t) ? e_cmd[t] : 4'b0111;
        tg = e_tag.exists(t) ? e_tag[t] : "R12 nop";
        chk({tg, " (R2 pins)"}, 128'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 128'(xc));
        if (e_cmd.exists(t)) chk({tg, " addr"}, 128'(sd_addr), 128'(e_addr[t]));
        chk("R8 oe", 128'(sd_dq_oe), 128'(e_wr.exists(t)));
        if (e_wr.exists(t)) chk("R8 wdata", sd_dq_out, wword(e_wr[t]));
        if (e_wr.exists(t))        xm = t_mask[e_wr[t]];
        else if (e_dqm0.exists(t)) xm = 16'h0000;
        else                       xm = 16'hFFFF;
        chk(e_wr.exists(t) ? "R8 dqm" : "R9 dqm", 128'(sd_dqm), 128'(xm));
        xrdy = (t >= ready_from);
        chk("R4 ready", 128'(ready), 128'(xrdy));
        chk("R10 rd_valid", 128'(rd_valid), 128'(e_rdv.exists(t)));
        chk("R10 rd_data", rd_data, e_rdv.exists(t) ? inword(t) : 128'(0));
        chk("R11 cke/dsf", 128'({sd_cke, sd_dsf}), 128'(2'b10));
    endtask

    initial begin
        int cyc, nxt, hold, dead;
        bit done;
        // R1: outputs during reset
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R1 cs_n", 128'(sd_cs_n), 128'(1));
            chk("R1 oe", 128'(sd_dq_oe), 128'(0));
            chk("R1 dqm", 128'(sd_dqm), 128'(16'hFFFF));
            chk("R1 ready/rd_valid", 128'({ready, rd_valid}), 128'(0));
        end
        rst = 1'b0;
        // R3: close all banks first, then mode load with latency in bits 6:4
        put(0, 4'b0010, 11'h200, "R3 close-all");
        put(RP, 4'b0000, 11'(CL << 4), "R3 mode");
        ready_from = RP + MRD - 1;
        last_cmd   = RP;
        cyc = -1; nxt = 0; hold = 0; dead = 0; done = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            sd_dq_in = inword(cyc);
            if (nxt < NREQ && hold == 0) begin
                // held valid through busy cycles: R4 ignore while not ready
                req_valid = 1'b1;
                req_write = t_wr[nxt];
                req_bank  = t_bank[nxt];
                req_row   = t_row[nxt];
                req_col   = t_col[nxt];
                req_wdata = wword(nxt);
                req_wmask = t_mask[nxt];
            end else begin
                req_valid = 1'b0;
                req_wdata = '1;
                if (hold > 0) hold--;
            end
            #1;
            compare_cycle(cyc);
            if (req_valid && cyc >= ready_from) begin
                schedule(cyc, nxt);
                nxt++;
                if (nxt == 3) hold = 5;
            end
            if (nxt == NREQ && cyc > last_cmd + CL + 4) done = 1;
            dead++;
            if (dead > 5000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
                done = 1;
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule